// File: doc/BRIEF.md
# Start-Stop Test Pattern Sequencer

This block walks a 6-bit pattern address through a programmed window, once for each circuit on a board under test. Each sweep begins at a start location. It advances one step each time the pattern consumer signals that a bit has been used. The sweep ends at a stop location, once the error check of that final bit has been reported. After that, the block selects the next circuit and runs the same window again. When the last circuit finishes, the block raises a board-complete flag.

The sequencer only works while the functional-test phase input is high. When that phase begins, the block takes in the start location, the stop location and the circuit count, and uses those values for the rest of the phase. It flags an invalid window instead of sweeping it. It reports a zero circuit count as an immediate board completion. Leaving the phase returns every output to its idle value.

Top module: `sweep_seq_top`

## Requirements
- R1: While reset is held and in the idle state after reset, `y_addr`, `circuit_sel`, `circuit_done`, `board_done` and `cfg_err` are all zero.
- R2: When `phase_active` is sampled high in the idle state with a nonzero count and a valid window (1 <= start <= stop), `y_addr` equals the start location and `circuit_sel` equals 0 one cycle later. Start, stop and count are captured at that edge, so later changes on `start_loc`, `stop_loc` or `circuit_total` have no effect until the phase is left.
- R3: While sweeping with `y_addr` below the stop location, each cycle with `bit_adv` high raises `y_addr` by one on the next cycle. `chk_done` has no effect at those addresses: there is no `circuit_done` and no reload.
- R4: While `y_addr` equals the stop location, `bit_adv` is ignored and `y_addr` holds. A cycle with `chk_done` high makes `circuit_done` high on the next cycle, and for that one cycle only.
- R5: For a circuit that is not the last, `y_addr` returns to the captured start location and `circuit_sel` rises by one in the same cycle that `circuit_done` is high.
- R6: For the last circuit (`circuit_sel` = count - 1), `board_done` rises together with `circuit_done`. `circuit_sel` keeps its value, and `board_done` stays high for as long as `phase_active` stays high.
- R7: A captured count of zero makes `board_done` high one cycle after phase entry. No sweep takes place and `y_addr` stays 0. A zero count takes precedence over a window error.
- R8: A start location of 0, or a stop location below the start location (with a nonzero count), makes `cfg_err` high one cycle after phase entry. `y_addr` then stays 0 and `bit_adv` and `chk_done` have no effect.
- R9: One cycle after `phase_active` is sampled low, `y_addr`, `circuit_sel`, `circuit_done`, `board_done` and `cfg_err` are zero. Entering the phase again starts a fresh capture.
- R10: `board_done` and `cfg_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| phase_active | input | 1 | Functional-test phase enable |
| start_loc | input | 6 | First pattern location of the window |
| stop_loc | input | 6 | Last pattern location of the window |
| circuit_total | input | 4 | Number of circuits to sweep |
| bit_adv | input | 1 | Current pattern bit consumed, step to the next one |
| chk_done | input | 1 | Error check of the current bit has finished |
| y_addr | output | 6 | Current pattern address |
| circuit_sel | output | 4 | Index of the circuit being tested |
| circuit_done | output | 1 | One-cycle pulse when a circuit's sweep finishes |
| board_done | output | 1 | All circuits finished (or count was zero) |
| cfg_err | output | 1 | Invalid window captured at phase entry |

## Verification
Every output comes from a register, so each result is due exactly one clock after the edge that samples its cause. That holds for the address step after `bit_adv`, for the completion pulse, reload and select step after `chk_done` at the stop location, for the capture, error or zero-count result after phase entry, and for the clear after phase exit. The bench drives inputs on falling edges and holds each strobe for a single cycle. It checks the outputs at the next falling edge, and then once more a cycle later to confirm that pulses have dropped and that held values remain. The sweep covers a grid of start locations, window lengths and circuit counts. At every non-stop address it adds a stray `chk_done`, and at every stop address it adds a stray `bit_adv`. After capture it scrambles the configuration inputs.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_DONE  = 2'd2,
    ST_ERR   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sweep_rst_sync.sv
module sweep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/sweep_addr_gen.sv
module sweep_addr_gen #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic              reload,
  input  logic              inc,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] stop_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              at_stop_o,
  output logic              cfg_bad_o
);
  logic [ADDR_W-1:0] start_q, stop_q, addr_q;
  logic [ADDR_W-1:0] start_d, stop_d, addr_d;
  logic              win_en, addr_en;

  // window registers: loaded at capture, cleared outside the phase
  assign win_en = clr | cap;
  always_comb begin
    start_d = start_q;
    stop_d  = stop_q;
    if (clr) begin
      start_d = '0;
      stop_d  = '0;
    end else if (cap) begin
      start_d = start_i;
      stop_d  = stop_i;
    end
  end

  // address register: clear, load, reload or step
  assign addr_en = clr | cap | reload | inc;
  always_comb begin
    addr_d = addr_q;
    if (clr)         addr_d = '0;
    else if (cap)    addr_d = start_i;
    else if (reload) addr_d = start_q;
    else if (inc)    addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      stop_q  <= '0;
    end else if (win_en) begin
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o    = addr_q;
  assign at_stop_o = (addr_q == stop_q);
  assign cfg_bad_o = (start_i == '0) || (stop_i < start_i);
endmodule

// File: rtl/sweep_circ_ctr.sv
module sweep_circ_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap,
  input  logic             step,
  input  logic [CNT_W-1:0] total_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] total_q, total_d, idx_q, idx_d;
  logic             en;
  logic [CNT_W:0]   idx_nxt;

  assign en = clr | cap | step;

  always_comb begin
    total_d = total_q;
    idx_d   = idx_q;
    if (clr) begin
      total_d = '0;
      idx_d   = '0;
    end else if (cap) begin
      total_d = total_i;
      idx_d   = '0;
    end else if (step) begin
      idx_d   = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      idx_q   <= '0;
    end else if (en) begin
      total_q <= total_d;
      idx_q   <= idx_d;
    end
  end

  assign idx_nxt = {1'b0, idx_q} + 1'b1;
  assign last_o  = (idx_nxt == {1'b0, total_q});
  assign zero_o  = (total_i == '0);
  assign idx_o   = idx_q;
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_i,
  input  logic       zero_i,
  input  logic       cfg_bad_i,
  input  logic       at_stop_i,
  input  logic       last_i,
  input  logic       adv_i,
  input  logic       chk_i,
  output logic       clr_o,
  output logic       cap_o,
  output logic       reload_o,
  output logic       inc_o,
  output logic       step_o,
  output logic       done_pulse_o,
  output seq_state_e state_o
);
  seq_state_e st_q, st_d;
  logic       pulse_q, pulse_d;

  always_comb begin
    st_d     = st_q;
    pulse_d  = 1'b0;
    clr_o    = 1'b0;
    cap_o    = 1'b0;
    reload_o = 1'b0;
    inc_o    = 1'b0;
    step_o   = 1'b0;
    if (!phase_i) begin
      st_d  = ST_IDLE;
      clr_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (zero_i)         st_d = ST_DONE;
          else if (cfg_bad_i) st_d = ST_ERR;
          else begin
            st_d  = ST_SWEEP;
            cap_o = 1'b1;
          end
        end
        ST_SWEEP: begin
          if (at_stop_i) begin
            if (chk_i) begin
              pulse_d = 1'b1;
              if (last_i) st_d = ST_DONE;
              else begin
                reload_o = 1'b1;
                step_o   = 1'b1;
              end
            end
          end else if (adv_i) begin
            inc_o = 1'b1;
          end
        end
        ST_DONE: st_d = ST_DONE;
        ST_ERR:  st_d = ST_ERR;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= pulse_d;
    end
  end

  assign done_pulse_o = pulse_q;
  assign state_o      = st_q;
endmodule

// File: rtl/sweep_seq_top.sv
module sweep_seq_top
  import sweep_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_active,
  input  logic [ADDR_W-1:0] start_loc,
  input  logic [ADDR_W-1:0] stop_loc,
  input  logic [CNT_W-1:0]  circuit_total,
  input  logic              bit_adv,
  input  logic              chk_done,
  output logic [ADDR_W-1:0] y_addr,
  output logic [CNT_W-1:0]  circuit_sel,
  output logic              circuit_done,
  output logic              board_done,
  output logic              cfg_err
);
  logic       rst_n_int;
  logic       clr, cap, reload, inc, step;
  logic       at_stop, cfg_bad, last, zero;
  seq_state_e state;

  sweep_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_int)
  );

  sweep_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n_int), .clr(clr), .cap(cap), .reload(reload),
    .inc(inc), .start_i(start_loc), .stop_i(stop_loc), .addr_o(y_addr),
    .at_stop_o(at_stop), .cfg_bad_o(cfg_bad)
  );

  sweep_circ_ctr #(.CNT_W(CNT_W)) u_circ (
    .clk(clk), .rst_n(rst_n_int), .clr(clr), .cap(cap), .step(step),
    .total_i(circuit_total), .idx_o(circuit_sel), .last_o(last),
    .zero_o(zero)
  );

  sweep_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .phase_i(phase_active), .zero_i(zero),
    .cfg_bad_i(cfg_bad), .at_stop_i(at_stop), .last_i(last),
    .adv_i(bit_adv), .chk_i(chk_done), .clr_o(clr), .cap_o(cap),
    .reload_o(reload), .inc_o(inc), .step_o(step),
    .done_pulse_o(circuit_done), .state_o(state)
  );

  assign board_done = (state == ST_DONE);
  assign cfg_err    = (state == ST_ERR);
endmodule

// File: rtl/sweep_seq_chk.sv
module sweep_seq_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phase_active,
  input logic              chk_done,
  input logic [ADDR_W-1:0] y_addr,
  input logic [CNT_W-1:0]  circuit_sel,
  input logic              circuit_done,
  input logic              board_done,
  input logic              cfg_err
);
  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    circuit_done |=> !circuit_done);

  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    circuit_done |-> $past(chk_done));

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(board_done && cfg_err));

  // R9
  phase_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_active |=> (y_addr == '0) && (circuit_sel == '0) && !circuit_done
                      && !board_done && !cfg_err);

  // R6
  board_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (board_done && phase_active) |=> board_done);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (y_addr == '0) && !circuit_done);
endmodule

bind sweep_seq_top sweep_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_active(phase_active), .chk_done(chk_done),
  .y_addr(y_addr), .circuit_sel(circuit_sel), .circuit_done(circuit_done),
  .board_done(board_done), .cfg_err(cfg_err)
);

// File: tb/sweep_seq_top_bench.sv
module sweep_seq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_active = 1'b0;
  logic [5:0] start_loc = '0, stop_loc = '0;
  logic [3:0] circuit_total = '0;
  logic       bit_adv = 1'b0, chk_done = 1'b0;
  logic [5:0] y_addr;
  logic [3:0] circuit_sel;
  logic       circuit_done, board_done, cfg_err;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sweep_seq_top u_sweep_seq_top (
    .clk(clk), .rst_n(rst_n), .phase_active(phase_active),
    .start_loc(start_loc), .stop_loc(stop_loc), .circuit_total(circuit_total),
    .bit_adv(bit_adv), .chk_done(chk_done), .y_addr(y_addr),
    .circuit_sel(circuit_sel), .circuit_done(circuit_done),
    .board_done(board_done), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_idle(input string req);
    check({req, " y_addr"}, y_addr, 0);
    check({req, " circuit_sel"}, circuit_sel, 0);
    check({req, " circuit_done"}, circuit_done, 0);
    check({req, " board_done"}, board_done, 0);
    check({req, " cfg_err"}, cfg_err, 0);
  endtask

  task automatic run_case(input int s, input int e, input int n);
    phase_active = 1'b1;
    start_loc = 6'(s); stop_loc = 6'(e); circuit_total = 4'(n);
    tick();
    check("R2 entry y_addr", y_addr, s);
    check("R2 entry circuit_sel", circuit_sel, 0);
    check("R2 entry flags", {board_done, cfg_err}, 0);
    // scramble inputs: captured values must rule (R2)
    start_loc = 6'(e + 1); stop_loc = 6'(s - 1); circuit_total = 4'(n + 5);
    for (int c = 0; c < n; c++) begin
      for (int a = s; a <= e; a++) begin
        check("R3 y_addr", y_addr, a);
        if (a != e) begin
          bit_adv = 1'b1; chk_done = 1'b1;
          tick();
          bit_adv = 1'b0; chk_done = 1'b0;
          check("R3 step", y_addr, a + 1);
          check("R3 no early done", circuit_done, 0);
        end else begin
          bit_adv = 1'b1;
          tick();
          bit_adv = 1'b0;
          check("R4 hold at stop", y_addr, e);
          check("R4 no done without check", circuit_done, 0);
          chk_done = 1'b1;
          tick();
          chk_done = 1'b0;
          check("R4 circuit_done", circuit_done, 1);
          if (c < n - 1) begin
            check("R5 reload", y_addr, s);
            check("R5 next circuit", circuit_sel, c + 1);
            check("R5 no board_done", board_done, 0);
          end else begin
            check("R6 board_done", board_done, 1);
            check("R6 sel holds", circuit_sel, c);
          end
          tick();
          check("R4 pulse drops", circuit_done, 0);
        end
      end
    end
    tick(); tick();
    check("R6 board_done held", board_done, 1);
    phase_active = 1'b0;
    tick();
    check_idle("R9 exit");
  endtask

  initial begin
    int starts[5] = '{1, 2, 17, 62, 63};
    int lens[3]   = '{0, 1, 4};
    repeat (3) tick();
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) tick();
    check_idle("R1 after reset");

    foreach (starts[i])
      foreach (lens[j])
        for (int n = 1; n <= 3; n++) begin
          int e;
          e = starts[i] + lens[j];
          if (e > 63) e = 63;
          run_case(starts[i], e, n);
        end

    // R7 zero count, also with a bad window (zero count wins)
    for (int k = 0; k < 2; k++) begin
      phase_active = 1'b1; circuit_total = 4'd0;
      start_loc = (k == 0) ? 6'd3 : 6'd9; stop_loc = 6'd5;
      tick();
      check("R7 board_done", board_done, 1);
      check("R7 cfg_err low", cfg_err, 0);
      bit_adv = 1'b1;
      tick();
      bit_adv = 1'b0;
      check("R7 no sweep", y_addr, 0);
      phase_active = 1'b0;
      tick();
      check_idle("R9 exit after zero");
    end

    // R8 bad windows
    for (int k = 0; k < 2; k++) begin
      phase_active = 1'b1; circuit_total = 4'd2;
      start_loc = (k == 0) ? 6'd0 : 6'd20; stop_loc = 6'd10;
      tick();
      check("R8 cfg_err", cfg_err, 1);
      check("R10 board_done low", board_done, 0);
      bit_adv = 1'b1; chk_done = 1'b1;
      tick();
      bit_adv = 1'b0; chk_done = 1'b0;
      check("R8 y_addr still", y_addr, 0);
      check("R8 no circuit_done", circuit_done, 0);
      phase_active = 1'b0;
      tick();
      check_idle("R9 exit after error");
    end

    // R9 exit mid-sweep, then fresh restart
    phase_active = 1'b1; start_loc = 6'd10; stop_loc = 6'd20; circuit_total = 4'd2;
    tick();
    bit_adv = 1'b1; tick(); tick(); bit_adv = 1'b0;
    check("R3 two steps", y_addr, 12);
    phase_active = 1'b0;
    tick();
    check_idle("R9 mid-sweep exit");
    phase_active = 1'b1; start_loc = 6'd40; stop_loc = 6'd41;
    tick();
    check("R9 restart y_addr", y_addr, 40);
    phase_active = 1'b0;
    tick();
    check_idle("R9 final exit");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule